// File: doc/BRIEF.md
# Dual-Scheme Memory Page Mapper

This block turns a 16-bit CPU address into a physical memory selection for a 64K space split into eight 8K sections (section number = address bits 15:13). Two paging schemes drive it. A bank latch, in the style of 128K home computers, picks the RAM bank shown in the top 16K, the ROM page in the bottom 16K, and which of two RAM banks the video fetch reads. A section-overlay mask can replace any 8K section with the matching section of one of two 64K external spaces, called DOCK and EX here. A single source bit chooses which of the two spaces is used, so both can never be active at once.

The schemes interact under fixed priority rules. In the top 16K an odd latched bank always wins over overlay mask bits 6 and 7. With an odd bank selected, mask bits 2 and 3 also overlay the low and high halves of the top 16K. The decode path is purely combinational from the address to the select outputs. Latch writes take effect one clock after their strobe. The block has no data stream, so every pin is a plain control or status pin with no handshake.

Top module: `dual_page_mapper`

## Requirements
- R1: After reset the mask reads 0x00 and the video select is 0. Address 0x0000 selects ROM page 0, and address 0xC000 selects home RAM bank 0.
- R2: Bank-latch bits 2:0 give the home bank for sections 6 and 7. Bit 4 gives the ROM page for sections 0 and 1. Bit 3 drives the video select. Bits 7:5 have no effect on any output.
- R3: With no overlay, sections 2 and 3 select home bank 5 and sections 4 and 5 select home bank 8.
- R4: With mask bit n set for a section n in 0..5, that section selects overlay memory with page output n and bank output 0.
- R5: The source bit written as 0 makes every overlaid section report kind DOCK (2), and written as 1 makes it report kind EX (3).
- R6: With an even latched bank, sections 6 and 7 are overlaid exactly when mask bits 6 and 7 are set.
- R7: With an odd latched bank, mask bits 6 and 7 have no effect. Sections 6 and 7 are then overlaid exactly when mask bits 2 and 3 are set.
- R8: The mask read port returns the last value written to the mask and holds it until the next mask write.
- R9: The video select depends only on bank-latch bit 3. Mask and source writes never change it.
- R10: A strobed write changes the outputs only after the next rising clock edge. Kind encoding: 0 ROM, 1 home RAM, 2 DOCK, 3 EX. For ROM and home RAM the page output is {2'b00, address bit 13}, and the bank output is the ROM page or home bank number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| bank_wr | input | 1 | Bank-latch write strobe |
| bank_wdata | input | 8 | Bank-latch write value |
| mask_wr | input | 1 | Section-mask write strobe |
| mask_wdata | input | 8 | Section-mask write value |
| src_wr | input | 1 | Source-bit write strobe |
| src_bit | input | 1 | Overlay source: 0 DOCK, 1 EX |
| mask_rdata | output | 8 | Last written section mask |
| sel_kind | output | 2 | Memory kind selected |
| sel_bank | output | 4 | ROM page or home RAM bank |
| sel_page | output | 3 | 8K page or overlay section index |
| vid_bank7 | output | 1 | Video fetch bank: 0 bank 5, 1 bank 7 |

## Verification
The bank latch, the mask and the source bit can all be written in the same cycle. The top-16K decode then has to apply the odd-bank priority and the leak of mask bits 2 and 3 using all three new values together. The bench writes all three at once for every combination of the eight banks, the 256 mask values and both sources. It then sweeps all eight sections and compares each result with an arithmetic model of the priority rules. The junk upper latch bits are varied alongside, and mask writes are made in the same cycles as bank writes, so that these checks also confirm that neither reaches the video select.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  localparam int ADDR_W = 16;
  localparam int SECT_W = 3;
  localparam int NSECT  = 1 << SECT_W;
  localparam int BANK_W = 3;
  localparam int OBANK_W = BANK_W + 1;
  localparam int REG_W  = 8;

  typedef enum logic [1:0] {
    KIND_ROM  = 2'd0,
    KIND_HOME = 2'd1,
    KIND_DOCK = 2'd2,
    KIND_EX   = 2'd3
  } kind_e;

  localparam logic [OBANK_W-1:0] MID_BANK  = OBANK_W'(5);
  localparam logic [OBANK_W-1:0] HIGH_BANK = OBANK_W'(8);
endpackage

// File: rtl/page_regs.sv
module page_regs
  import pgmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr,
  input  logic [REG_W-1:0]  bank_wdata,
  input  logic              mask_wr,
  input  logic [NSECT-1:0]  mask_wdata,
  input  logic              src_wr,
  input  logic              src_bit,
  output logic [BANK_W-1:0] bank_q,
  output logic              rom_q,
  output logic              vid_q,
  output logic [NSECT-1:0]  mask_q,
  output logic              src_q
);
  localparam int VID_BIT = BANK_W;
  localparam int ROM_BIT = BANK_W + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      rom_q  <= 1'b0;
      vid_q  <= 1'b0;
      mask_q <= '0;
      src_q  <= 1'b0;
    end else begin
      if (bank_wr) begin
        bank_q <= bank_wdata[BANK_W-1:0];
        vid_q  <= bank_wdata[VID_BIT];
        rom_q  <= bank_wdata[ROM_BIT];
      end
      if (mask_wr) mask_q <= mask_wdata;
      if (src_wr)  src_q  <= src_bit;
    end
  end
endmodule

// File: rtl/section_router.sv
module section_router
  import pgmap_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BANK_W-1:0]  bank_q,
  input  logic               rom_q,
  input  logic [NSECT-1:0]   mask_q,
  input  logic               src_q,
  output logic [1:0]         kind,
  output logic [OBANK_W-1:0] bank,
  output logic [SECT_W-1:0]  page
);
  localparam int LEAK_DIST = NSECT / 2;

  logic [SECT_W-1:0] sect;
  logic [NSECT-1:0]  ovl_en;
  logic              odd_bank;

  assign sect     = addr[ADDR_W-1 -: SECT_W];
  assign odd_bank = bank_q[0];

  for (genvar s = 0; s < NSECT; s++) begin : g_ovl
    if (s >= NSECT - 2) begin : g_top
      assign ovl_en[s] = odd_bank ? mask_q[s-LEAK_DIST] : mask_q[s];
    end else begin : g_plain
      assign ovl_en[s] = mask_q[s];
    end
  end

  always_comb begin
    page = {{(SECT_W-1){1'b0}}, addr[ADDR_W-SECT_W]};
    bank = '0;
    kind = KIND_HOME;
    if (ovl_en[sect]) begin
      kind = src_q ? KIND_EX : KIND_DOCK;
      page = sect;
    end else begin
      unique case (sect[SECT_W-1 -: 2])
        2'd0: begin kind = KIND_ROM; bank = {{(OBANK_W-1){1'b0}}, rom_q}; end
        2'd1: bank = MID_BANK;
        2'd2: bank = HIGH_BANK;
        default: bank = {1'b0, bank_q};
      endcase
    end
  end
endmodule

// File: rtl/dual_page_mapper.sv
module dual_page_mapper
  import pgmap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        bank_wr,
  input  logic [7:0]  bank_wdata,
  input  logic        mask_wr,
  input  logic [7:0]  mask_wdata,
  input  logic        src_wr,
  input  logic        src_bit,
  output logic [7:0]  mask_rdata,
  output logic [1:0]  sel_kind,
  output logic [3:0]  sel_bank,
  output logic [2:0]  sel_page,
  output logic        vid_bank7
);
  logic [BANK_W-1:0] bank_q;
  logic              rom_q;
  logic              src_q;
  logic [NSECT-1:0]  mask_q;

  page_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bank_wr(bank_wr), .bank_wdata(bank_wdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .src_wr(src_wr), .src_bit(src_bit),
    .bank_q(bank_q), .rom_q(rom_q), .vid_q(vid_bank7),
    .mask_q(mask_q), .src_q(src_q)
  );

  section_router u_route (
    .addr(cpu_addr), .bank_q(bank_q), .rom_q(rom_q),
    .mask_q(mask_q), .src_q(src_q),
    .kind(sel_kind), .bank(sel_bank), .page(sel_page)
  );

  assign mask_rdata = mask_q;
endmodule

// File: rtl/pgmap_checker.sv
module pgmap_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        bank_wr,
  input logic        mask_wr,
  input logic [7:0]  mask_wdata,
  input logic        src_wr,
  input logic        src_bit,
  input logic [7:0]  mask_rdata,
  input logic [1:0]  sel_kind,
  input logic [3:0]  sel_bank,
  input logic [2:0]  bank_q,
  input logic        src_q,
  input logic        vid_bank7
);
  a_r1_reset_clear: assert property (@(posedge clk)
    (!rst_n && !mask_wr) |=> (mask_rdata == 8'h00));

  a_r8_mask_capture: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_rdata == $past(mask_wdata)));

  a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_rdata));

  a_r5_source_capture: assert property (@(posedge clk) disable iff (!rst_n)
    src_wr |=> (src_q == $past(src_bit)));

  a_r9_video_only_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wr |=> $stable(vid_bank7));

  a_r3_mid_bank5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b01 && !mask_rdata[{2'b01, cpu_addr[13]}])
      |-> (sel_kind == 2'd1 && sel_bank == 4'd5));

  a_r7_top_overlay_source: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b11 && sel_kind[1])
      |-> (bank_q[0] ? mask_rdata[{2'b01, cpu_addr[13]}]
                     : mask_rdata[cpu_addr[15:13]]));
endmodule

bind dual_page_mapper pgmap_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
  .bank_wr(bank_wr), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
  .src_wr(src_wr), .src_bit(src_bit), .mask_rdata(mask_rdata),
  .sel_kind(sel_kind), .sel_bank(sel_bank),
  .bank_q(bank_q), .src_q(src_q), .vid_bank7(vid_bank7)
);

// File: tb/tb_dual_page_mapper.sv
module tb_dual_page_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        bank_wr = 1'b0, mask_wr = 1'b0, src_wr = 1'b0, src_bit = 1'b0;
  logic [7:0]  bank_wdata = '0, mask_wdata = '0;
  logic [7:0]  mask_rdata;
  logic [1:0]  sel_kind;
  logic [3:0]  sel_bank;
  logic [2:0]  sel_page;
  logic        vid_bank7;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_page_mapper dut (.*);

  // Expected {kind, bank, page} from the requirements.
  function automatic logic [8:0] model(input logic [2:0] s, input logic [2:0] b,
                                       input logic r, input logic [7:0] m, input logic x);
    logic ov;
    ov = m[s];
    if (s >= 3'd6 && b[0]) ov = m[s - 3'd4];          // R7 leak; R6 otherwise
    if (ov) return {(x ? 2'd3 : 2'd2), 4'd0, s};      // R4, R5
    case (s[2:1])
      2'd0: return {2'd0, 3'd0, r, 2'd0, s[0]};       // R2 ROM page
      2'd1: return {2'd1, 4'd5, 2'd0, s[0]};          // R3
      2'd2: return {2'd1, 4'd8, 2'd0, s[0]};          // R3
      default: return {2'd1, 1'b0, b, 2'd0, s[0]};    // R2 bank
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_all(input logic [7:0] bw, input logic [7:0] mw, input logic sb);
    @(negedge clk);
    bank_wr = 1'b1; bank_wdata = bw;
    mask_wr = 1'b1; mask_wdata = mw;
    src_wr = 1'b1; src_bit = sb;
    @(negedge clk);
    bank_wr = 1'b0; mask_wr = 1'b0; src_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", {8'd0, mask_rdata}, 16'h0000);
    chk("R1 video", {15'd0, vid_bank7}, 16'h0000);
    cpu_addr = 16'h0000; #1;
    chk("R1 rom0", {7'd0, sel_kind, sel_bank, sel_page}, {7'd0, 9'b00_0000_000});
    cpu_addr = 16'hC000; #1;
    chk("R1 bank0", {7'd0, sel_kind, sel_bank, sel_page}, {7'd0, 9'b01_0000_000});

    // R10 write visible only after the edge
    @(negedge clk);
    mask_wr = 1'b1; mask_wdata = 8'hFF; cpu_addr = 16'h4000; #1;
    chk("R10 before edge mask", {8'd0, mask_rdata}, 16'h0000);
    chk("R10 before edge kind", {14'd0, sel_kind}, 16'd1);
    @(negedge clk);
    mask_wr = 1'b0; #1;
    chk("R10 after edge kind", {14'd0, sel_kind}, 16'd2);

    // Exhaustive sweep of latch, mask and source written in the same cycle
    for (int b = 0; b < 8; b++) begin
      for (int x = 0; x < 2; x++) begin
        for (int m = 0; m < 256; m++) begin
          logic r;
          logic [7:0] bw;
          r  = b[0] ^ x[0] ^ m[0];
          bw = {m[7:5] ^ 3'b101, r, b[1], b[2:0]};  // bits 7:5 junk (R2)
          write_all(bw, m[7:0], x[0]);
          chk("R8 readback", {8'd0, mask_rdata}, {8'd0, m[7:0]});
          chk("R9 video", {15'd0, vid_bank7}, {15'd0, b[1]});
          for (int s = 0; s < 8; s++) begin
            logic [8:0] e;
            cpu_addr = {s[2:0], 13'(m * 37 + b * 5 + s)};
            #1;
            e = model(s[2:0], b[2:0], r, m[7:0], x[0]);
            if (s >= 6) chk(b[0] ? "R7 top odd" : "R6 top even",
                            {7'd0, sel_kind, sel_bank, sel_page}, {7'd0, e});
            else if (e[8]) chk("R4 R5 overlay",
                            {7'd0, sel_kind, sel_bank, sel_page}, {7'd0, e});
            else chk("R2 R3 home rom",
                            {7'd0, sel_kind, sel_bank, sel_page}, {7'd0, e});
          end
        end
      end
    end

    // R8 hold: a bank write alone leaves the mask value
    write_all(8'h03, 8'h5A, 1'b1);
    @(negedge clk); bank_wr = 1'b1; bank_wdata = 8'h0E;
    @(negedge clk); bank_wr = 1'b0;
    chk("R8 hold", {8'd0, mask_rdata}, 16'h005A);
    chk("R9 video set", {15'd0, vid_bank7}, 16'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule